// File: doc/BRIEF.md
# Stochastic Boolean Network Simulation Sequencer

This block drives a discrete Boolean network through a simulation run. It holds one state bit per network element and evaluates a combinational next-state function on a masked copy of that state. The mask is an inhibitor vector captured when a run begins, and it pins chosen elements at zero. In the two sequential modes, an external rule selector supplies an element index together with a valid flag. Only the indexed element takes its computed next value. In the simultaneous mode, every element updates on every cycle and the selector is left idle.

The sequencer keeps a set of tracking bits that record which elements have been written in the current round. When all of them are set, it raises a round flag and clears the set on the following edge. A separate comparison raises a steady flag when the state after the latest load matches the state before it. A run stops after a programmed count of events: accepted loads in step mode, completed rounds in round mode, or cycles in simultaneous mode. It then pulses done and waits for the next start. The example next-state rule is a ring in which each element ORs itself with its lower neighbour. It stands in for a model-specific rule set.

Top module: `netsim_ctrl`

## Requirements
- R1: After reset, `state` is all zero and `busy`, `done`, `round_done`, `steady` and `sel_en` are all low.
- R2: A `start` seen while idle captures `mode`, `limit` and `inhibit`, loads `state` with `init_state & ~inhibit`, clears tracking, count and steady history, and makes `busy` high on the next edge. A `start` seen while busy has no effect on `state`.
- R3: In step mode (`mode`=0) or round mode (`mode`=1; code 3 behaves as step), `sel_en` is high while busy. A cycle with `sel_valid` high and `sel_idx` < N_ELEM replaces only bit `sel_idx` of `state` with its next-state value at the next edge. `sel_en` and `round_done` are low while idle.
- R4: The next value of element i is m[i] | m[(i+N_ELEM-1) mod N_ELEM], where m is `state & ~inhibit`.
- R5: A cycle where `sel_valid` is low, or where `sel_idx` ≥ N_ELEM, leaves `state` and the steady history unchanged and is not counted as a step.
- R6: `round_done` is high while busy once every element has been loaded since the current round began. On the following edge the tracking bits are cleared, and an index accepted in that same cycle counts toward the new round.
- R7: `steady` is high when at least one load has occurred since start and `state` equals the masked state that was present just before the latest load.
- R8: Bits selected by `inhibit` stay zero for the whole run, whatever the next-state function gives.
- R9: In simultaneous mode (`mode`=2), all elements take their next-state values on every busy cycle and `sel_en` stays low.
- R10: The run ends when the count of events reaches `limit` (0 acts as 1). Events are accepted loads in step mode, cycles with `round_done` high in round mode, and busy cycles in simultaneous mode. On the edge after the final event, `done` goes high for exactly one cycle and `busy` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| mode | input | 2 | 0 step, 1 round, 2 simultaneous, 3 as step |
| init_state | input | N_ELEM | Initial element values |
| inhibit | input | N_ELEM | Elements forced to zero for the run |
| limit | input | CNT_W | Number of events in a run |
| sel_en | output | 1 | Request to the rule selector |
| sel_idx | input | IDX_W | Element index from the rule selector |
| sel_valid | input | 1 | Index qualifier |
| state | output | N_ELEM | Current element values |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| round_done | output | 1 | All elements loaded in this round |
| steady | output | 1 | Latest load left the state unchanged |

## Verification
The bench builds the block with N_ELEM=5 and CNT_W=8, which gives IDX_W=3. Five elements make the index field wide enough to carry the out-of-range codes 5 to 7, so the bench can test how the sequencer rejects them. An odd ring also makes the neighbour wrap from element 0 to element 4 visible in the table walk. An 8-bit limit keeps the step, round and simultaneous end-of-run cases down to a few cycles each.

// File: rtl/netsim_pkg.sv
package netsim_pkg;

    typedef enum logic [1:0] {
        MODE_STEP  = 2'd0,
        MODE_ROUND = 2'd1,
        MODE_SIMUL = 2'd2,
        MODE_ALT   = 2'd3
    } sim_mode_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/netsim_rules.sv
module netsim_rules #(
    parameter int N_ELEM = 5
) (
    input  logic [N_ELEM-1:0] masked,
    output logic [N_ELEM-1:0] nxt
);
    // Example ring network: each element ORs itself with its lower neighbour.
    for (genvar i = 0; i < N_ELEM; i++) begin : g_elem
        assign nxt[i] = masked[i] | masked[(i + N_ELEM - 1) % N_ELEM];
    end
endmodule

// File: rtl/netsim_cmp.sv
module netsim_cmp #(
    parameter int W = 5
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq
);
    assign eq = (a == b);
endmodule

// File: rtl/netsim_ctrl.sv
module netsim_ctrl
    import netsim_pkg::*;
#(
    parameter int N_ELEM = 5,
    parameter int CNT_W  = 16,
    localparam int IDX_W = $clog2(N_ELEM + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [N_ELEM-1:0] init_state,
    input  logic [N_ELEM-1:0] inhibit,
    input  logic [CNT_W-1:0]  limit,
    output logic              sel_en,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic              sel_valid,
    output logic [N_ELEM-1:0] state,
    output logic              busy,
    output logic              done,
    output logic              round_done,
    output logic              steady
);

    localparam logic [N_ELEM-1:0] ALL_SET = {N_ELEM{1'b1}};

    typedef struct packed {
        phase_e            phase;
        logic [1:0]        mode;
        logic [N_ELEM-1:0] cur;
        logic [N_ELEM-1:0] prev;
        logic [N_ELEM-1:0] upd;
        logic [N_ELEM-1:0] inh;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  lim;
        logic              have_prev;
        logic              done;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic [N_ELEM-1:0] masked;
    logic [N_ELEM-1:0] nxt_vec;
    logic              round_full;
    logic              same_state;
    logic              run;
    logic              seq_mode;
    logic              idx_ok;
    logic              load_one;
    logic              load_all;
    logic              count_evt;
    logic              last_evt;

    assign masked = r_q.cur & ~r_q.inh;

    netsim_rules #(.N_ELEM(N_ELEM)) rules_i (
        .masked (masked),
        .nxt    (nxt_vec)
    );

    netsim_cmp #(.W(N_ELEM)) cmp_round_i (
        .a  (r_q.upd),
        .b  (ALL_SET),
        .eq (round_full)
    );

    netsim_cmp #(.W(N_ELEM)) cmp_steady_i (
        .a  (r_q.cur),
        .b  (r_q.prev),
        .eq (same_state)
    );

    always_comb begin
        run      = (r_q.phase == PH_RUN);
        seq_mode = (r_q.mode != MODE_SIMUL);
        idx_ok   = sel_valid && (sel_idx < IDX_W'(N_ELEM));
        load_one = run && seq_mode && idx_ok;
        load_all = run && !seq_mode;
        case (r_q.mode)
            MODE_ROUND: count_evt = run && round_full;
            MODE_SIMUL: count_evt = run;
            default:    count_evt = load_one;
        endcase
        last_evt = ({1'b0, r_q.cnt} + 1'b1) >= {1'b0, r_q.lim};

        r_d      = r_q;
        r_d.done = 1'b0;

        if (!run) begin
            if (start) begin
                r_d.phase     = PH_RUN;
                r_d.mode      = mode;
                r_d.cur       = init_state & ~inhibit;
                r_d.inh       = inhibit;
                r_d.prev      = '0;
                r_d.upd       = '0;
                r_d.cnt       = '0;
                r_d.lim       = limit;
                r_d.have_prev = 1'b0;
            end
        end else begin
            if (round_full) begin
                r_d.upd = '0;
            end
            if (load_one) begin
                for (int i = 0; i < N_ELEM; i++) begin
                    if (IDX_W'(i) == sel_idx) begin
                        r_d.cur[i] = nxt_vec[i] & ~r_q.inh[i];
                        r_d.upd[i] = 1'b1;
                    end
                end
                r_d.prev      = masked;
                r_d.have_prev = 1'b1;
            end
            if (load_all) begin
                r_d.cur       = nxt_vec & ~r_q.inh;
                r_d.upd       = ALL_SET;
                r_d.prev      = masked;
                r_d.have_prev = 1'b1;
            end
            if (count_evt) begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (last_evt) begin
                    r_d.done  = 1'b1;
                    r_d.phase = PH_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state      = r_q.cur;
    assign busy       = run;
    assign done       = r_q.done;
    assign sel_en     = run && seq_mode;
    assign round_done = run && round_full;
    assign steady     = r_q.have_prev && same_state;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sel_en && !round_done)); // R3
    AST_ONE_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.mode != MODE_SIMUL) |=> ($countones(state ^ $past(state)) <= 1)); // R3
    AST_BAD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.mode != MODE_SIMUL && sel_valid && sel_idx >= IDX_W'(N_ELEM))
        |=> $stable(state)); // R5
    AST_INH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((state & r_q.inh) == '0)); // R8
    AST_SIMUL_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.mode == MODE_SIMUL) |-> !sel_en); // R9

endmodule

// File: tb/netsim_ctrl_tb.sv
`timescale 1ns/1ps
module netsim_ctrl_tb_top;

    localparam int N  = 5;
    localparam int CW = 8;
    localparam int IW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [N-1:0]  init_state = '0;
    logic [N-1:0]  inhibit = '0;
    logic [CW-1:0] limit = '0;
    logic          sel_en;
    logic [IW-1:0] sel_idx = '0;
    logic          sel_valid = 1'b0;
    logic [N-1:0]  state;
    logic          busy, done, round_done, steady;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    netsim_ctrl #(.N_ELEM(N), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .init_state(init_state), .inhibit(inhibit), .limit(limit),
        .sel_en(sel_en), .sel_idx(sel_idx), .sel_valid(sel_valid),
        .state(state), .busy(busy), .done(done),
        .round_done(round_done), .steady(steady)
    );

    // Step-mode walk from init 00001, no inhibit: index, state, steady, round flag.
    localparam int TBL_LEN = 7;
    localparam int TBL_IDX [TBL_LEN] = '{1, 4, 2, 0, 3, 4, 2};
    localparam int TBL_ST  [TBL_LEN] = '{5'h03, 5'h03, 5'h07, 5'h07, 5'h0F, 5'h1F, 5'h1F};
    localparam int TBL_STD [TBL_LEN] = '{0, 1, 0, 1, 0, 0, 1};
    localparam int TBL_RND [TBL_LEN] = '{0, 0, 0, 0, 1, 0, 0};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; sel_valid = 1'b0; sel_idx = '0;
        cyc(); cyc();
        rst_n = 1'b1;
    endtask

    task automatic begin_run(input logic [1:0] m, input logic [N-1:0] ini,
                             input logic [N-1:0] inh, input logic [CW-1:0] lim);
        mode = m; init_state = ini; inhibit = inh; limit = lim; start = 1'b1;
        cyc();
        start = 1'b0;
    endtask

    task automatic step(input int idx);
        sel_valid = 1'b1; sel_idx = IW'(idx);
        cyc();
        sel_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 state", state, 0);
        chk("R1 flags", {busy, done, round_done, steady, sel_en}, 0);

        // R2 start loads init; R3 request enable
        begin_run(2'd0, 5'b00001, 5'b00000, 8'd100);
        chk("R2 init load", state, 5'h01);
        chk("R2 busy", busy, 1);
        chk("R3 sel_en", sel_en, 1);
        chk("R7 no history", steady, 0);

        // Table walk: R3 R4 R6 R7
        for (int k = 0; k < TBL_LEN; k++) begin
            step(TBL_IDX[k]);
            chk("R4 table state", state, TBL_ST[k]);
            chk("R7 table steady", steady, TBL_STD[k]);
            chk("R6 table round", round_done, TBL_RND[k]);
        end

        // R5 out-of-range index and idle cycle ignored
        step(6);
        chk("R5 bad index state", state, 5'h1F);
        chk("R5 bad index steady", steady, 1);
        cyc();
        chk("R5 no valid", state, 5'h1F);
        // R2 start while busy ignored
        begin_run(2'd0, 5'b00000, 5'b00000, 8'd1);
        chk("R2 start while busy", state, 5'h1F);
        chk("R2 still busy", busy, 1);

        // R10 step-mode limit
        do_reset();
        begin_run(2'd0, 5'b00001, 5'b00000, 8'd3);
        step(1);
        step(7);
        step(1);
        cyc();
        chk("R10 not yet done", {busy, done}, 2'b10);
        step(2);
        chk("R10 step done", {busy, done}, 2'b01);
        chk("R10 step state", state, 5'h07);
        cyc();
        chk("R10 done single", done, 0);
        chk("R3 idle no enable", sel_en, 0);

        // R6 R10 round mode with duplicate index
        do_reset();
        begin_run(2'd1, 5'b00001, 5'b00000, 8'd1);
        step(0); step(0); step(1); step(2); step(3);
        chk("R6 duplicate no round", round_done, 0);
        chk("R4 round state", state, 5'h0F);
        step(4);
        chk("R6 round flag", round_done, 1);
        chk("R10 round busy", {busy, done}, 2'b10);
        cyc();
        chk("R10 round done", {busy, done}, 2'b01);
        chk("R4 round final", state, 5'h1F);

        // R9 R10 simultaneous mode
        do_reset();
        begin_run(2'd2, 5'b00001, 5'b00000, 8'd3);
        chk("R9 no enable", sel_en, 0);
        cyc();
        chk("R9 simul step1", state, 5'h03);
        cyc();
        chk("R9 simul step2", state, 5'h07);
        chk("R10 simul busy", {busy, done}, 2'b10);
        cyc();
        chk("R9 simul step3", state, 5'h0F);
        chk("R10 simul done", {busy, done}, 2'b01);

        // R8 inhibit forces bit 1 low
        do_reset();
        begin_run(2'd2, 5'b00011, 5'b00010, 8'd4);
        chk("R8 init masked", state, 5'h01);
        cyc();
        chk("R8 held", state, 5'h01);
        chk("R7 simul steady", steady, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule